// File: doc/BRIEF.md
# Direct Frequency Synthesis Clock Generator

This block derives a slower clock from a faster free-running system clock. A phase accumulator advances by a fixed increment on every enabled system clock edge and is taken modulo a non-power-of-two value. Each wrap of the accumulator marks one synthesized period. With the default settings (modulus 640, increment 243) a 204.8 MHz system clock yields exactly 77.76 MHz on average, with no long-term drift.

The synthesized output is a registered level that only changes on a system clock edge. Its edges therefore sit on the system clock grid, and each edge may be up to one system period off its ideal position. The output is high while the accumulator lies in the lower half of its range. A once-per-period strobe marks every wrap. A signed trim word, intended to come from a digital PLL loop filter, is added to the increment to pull the frequency. The sum is clamped so that the output always stays below half the system clock rate.

Top module: `dfs_synth`

## Requirements
- R1: While `rst_sys` is high at a clock edge, the accumulator becomes 0, `clk_dfs` becomes low and `tick` becomes low. The first enabled edge after reset therefore loads the increment itself.
- R2: On every edge with `en` high and `rst_sys` low, the accumulator becomes (accumulator + increment) mod 640. The increment is 243 when `trim` is 0.
- R3: After each enabled edge, `clk_dfs` is 1 when the new accumulator value is below 320 and 0 otherwise. It changes only at system clock edges.
- R4: `tick` is high for exactly the one cycle that follows an enabled edge at which the accumulator wrapped. With zero trim, any window of 640 enabled cycles holds exactly 243 ticks and 243 rising edges of `clk_dfs`.
- R5: `trim` is a two's-complement signed word added to the nominal increment. Over 640 enabled cycles the tick count equals the resulting increment.
- R6: The increment is clamped to the range 1 to 319 inclusive. A trim that takes the sum above 319 gives 319, and one that takes it below 1 gives 1.
- R7: While `en` is low, the accumulator and `clk_dfs` hold their values and `tick` stays low. Counting resumes from the held value once `en` returns high.
- R8: With zero trim, successive rising edges of `clk_dfs` are 2 or 3 system cycles apart. The output jitter never exceeds one system period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | Free-running system clock |
| rst_sys | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low freezes the accumulator |
| trim | input | TRIM_W (10) | Signed frequency pull added to the increment |
| clk_dfs | output | 1 | Synthesized clock level, edge-aligned to `clk_sys` |
| tick | output | 1 | One-cycle strobe per synthesized period |

## Verification
The bench uses the default parameters: modulus 640, nominal increment 243 and a 10-bit trim word. With a trim range of -512 to +511, both clamp limits can be reached from the nominal point, including the exact boundaries at trims of -242, -243, +76 and +77. Because the modulus is 640, a complete ratio cycle lasts only 640 system cycles. Each window therefore checks exact tick counts against the increment rather than an approximate rate. Every cycle is also compared against an independent arithmetic model of the accumulator rule.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

    // Default ratio: 243/640 gives 77.76 MHz from 204.8 MHz.
    localparam int unsigned DFS_MOD_DEF    = 640;
    localparam int unsigned DFS_INC_DEF    = 243;
    localparam int unsigned DFS_TRIM_W_DEF = 10;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } dfs_level_e;

endpackage

// File: rtl/dfs_incr_sat.sv
module dfs_incr_sat #(
    parameter int unsigned MOD    = 640,
    parameter int unsigned NOM    = 243,
    parameter int unsigned TRIM_W = 10,
    parameter int unsigned ACC_W  = 10
) (
    input  logic signed [TRIM_W-1:0] trim_i,
    output logic        [ACC_W-1:0]  inc_o
);
    localparam int unsigned HALF  = MOD / 2;
    localparam int unsigned SUM_W = ((TRIM_W > ACC_W + 1) ? TRIM_W : ACC_W + 1) + 1;

    localparam logic signed [SUM_W-1:0] LO_S  = SUM_W'(1);
    localparam logic signed [SUM_W-1:0] HI_S  = SUM_W'(HALF - 1);
    localparam logic signed [SUM_W-1:0] NOM_S = SUM_W'(NOM);

    logic signed [SUM_W-1:0] trim_ext;
    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] sat;

    always_comb begin
        trim_ext = {{(SUM_W - TRIM_W){trim_i[TRIM_W-1]}}, trim_i};
        sum      = NOM_S + trim_ext;
        if (sum < LO_S) begin
            sat = LO_S;
        end else if (sum > HI_S) begin
            sat = HI_S;
        end else begin
            sat = sum;
        end
        inc_o = ACC_W'(sat);
    end

endmodule

// File: rtl/dfs_phase_acc.sv
module dfs_phase_acc #(
    parameter int unsigned MOD   = 640,
    parameter int unsigned ACC_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [ACC_W-1:0] inc_i,
    output logic [ACC_W-1:0] phase_o,
    output logic [ACC_W-1:0] phase_nxt_o,
    output logic             wrap_o
);
    localparam logic [ACC_W:0] MOD_W = (ACC_W + 1)'(MOD);

    typedef struct packed {
        logic [ACC_W-1:0] phase;
        logic             wrap;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [ACC_W:0] raw;

    always_comb begin
        st_d      = st_q;
        st_d.wrap = 1'b0;
        raw       = {1'b0, st_q.phase} + {1'b0, inc_i};
        if (en) begin
            if (raw >= MOD_W) begin
                st_d.phase = ACC_W'(raw - MOD_W);
                st_d.wrap  = 1'b1;
            end else begin
                st_d.phase = ACC_W'(raw);
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign phase_o     = st_q.phase;
    assign phase_nxt_o = st_d.phase;
    assign wrap_o      = st_q.wrap;

    // R2
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.phase < ACC_W'(MOD));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(st_q.phase) && !st_q.wrap));

endmodule

// File: rtl/dfs_wave_gen.sv
module dfs_wave_gen
    import dfs_pkg::*;
#(
    parameter int unsigned MOD   = 640,
    parameter int unsigned ACC_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [ACC_W-1:0] phase_nxt_i,
    output logic             level_o
);
    localparam logic [ACC_W-1:0] HALF_W = ACC_W'(MOD / 2);

    typedef struct packed {
        dfs_level_e lvl;
    } wave_state_t;

    wave_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.lvl = (phase_nxt_i < HALF_W) ? LVL_HIGH : LVL_LOW;
        end
        if (rst) begin
            st_d.lvl = LVL_LOW;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign level_o = (st_q.lvl == LVL_HIGH);

    // R7
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(level_o));

endmodule

// File: rtl/dfs_synth.sv
module dfs_synth
    import dfs_pkg::*;
#(
    parameter int unsigned MOD    = DFS_MOD_DEF,
    parameter int unsigned NOM    = DFS_INC_DEF,
    parameter int unsigned TRIM_W = DFS_TRIM_W_DEF
) (
    input  logic                     clk_sys,
    input  logic                     rst_sys,
    input  logic                     en,
    input  logic signed [TRIM_W-1:0] trim,
    output logic                     clk_dfs,
    output logic                     tick
);
    localparam int unsigned ACC_W = $clog2(MOD);
    localparam int unsigned HALF  = MOD / 2;

    logic [ACC_W-1:0] inc_w;
    logic [ACC_W-1:0] phase_w;
    logic [ACC_W-1:0] phase_nxt_w;

    dfs_incr_sat #(
        .MOD    (MOD),
        .NOM    (NOM),
        .TRIM_W (TRIM_W),
        .ACC_W  (ACC_W)
    ) i_incr (
        .trim_i (trim),
        .inc_o  (inc_w)
    );

    dfs_phase_acc #(
        .MOD   (MOD),
        .ACC_W (ACC_W)
    ) i_acc (
        .clk         (clk_sys),
        .rst         (rst_sys),
        .en          (en),
        .inc_i       (inc_w),
        .phase_o     (phase_w),
        .phase_nxt_o (phase_nxt_w),
        .wrap_o      (tick)
    );

    dfs_wave_gen #(
        .MOD   (MOD),
        .ACC_W (ACC_W)
    ) i_wave (
        .clk         (clk_sys),
        .rst         (rst_sys),
        .en          (en),
        .phase_nxt_i (phase_nxt_w),
        .level_o     (clk_dfs)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk_sys)
        rst_sys |=> (phase_w == '0 && !clk_dfs && !tick));

    // R3
    level_match_chk: assert property (@(posedge clk_sys) disable iff (rst_sys)
        en |=> (clk_dfs == (phase_w < ACC_W'(HALF))));

    // R4
    tick_pulse_chk: assert property (@(posedge clk_sys) disable iff (rst_sys)
        tick |=> !tick);

    // R6
    incr_range_chk: assert property (@(posedge clk_sys) disable iff (rst_sys)
        (inc_w != '0) && (inc_w < ACC_W'(HALF)));

endmodule

// File: tb/test_dfs_synth.sv
`timescale 1ns/1ps
module test_dfs_synth;

    localparam int MOD    = 640;
    localparam int NOM    = 243;
    localparam int TRIM_W = 10;
    localparam int HALF   = MOD / 2;

    logic                     clk_sys = 1'b0;
    logic                     rst_sys = 1'b1;
    logic                     en      = 1'b0;
    logic signed [TRIM_W-1:0] trim    = '0;
    logic                     clk_dfs;
    logic                     tick;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // bench-side reference state
    int m_phase = 0;
    bit m_lvl   = 1'b0;
    bit m_tick  = 1'b0;

    // window counters
    int ticks_seen = 0;
    int rises_seen = 0;
    int cyc        = 0;
    int last_rise  = -1;
    bit prev_lvl   = 1'b0;
    bit gap_check  = 1'b0;

    dfs_synth #(.MOD(MOD), .NOM(NOM), .TRIM_W(TRIM_W)) i_dfs_synth (
        .clk_sys (clk_sys),
        .rst_sys (rst_sys),
        .en      (en),
        .trim    (trim),
        .clk_dfs (clk_dfs),
        .tick    (tick)
    );

    always #10 clk_sys = ~clk_sys;

    function automatic int exp_inc(int t);
        int s;
        s = NOM + t;
        if (s < 1) s = 1;
        if (s > HALF - 1) s = HALF - 1;
        return s;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // advance reference at the edge, compare at the following falling edge
    task automatic step(int n, string req);
        for (int k = 0; k < n; k++) begin
            @(posedge clk_sys);
            if (rst_sys) begin
                m_phase = 0; m_lvl = 1'b0; m_tick = 1'b0;
            end else if (en) begin
                m_phase = m_phase + exp_inc(int'(trim));
                m_tick  = (m_phase >= MOD);
                if (m_tick) m_phase = m_phase - MOD;
                m_lvl   = (m_phase < HALF);
            end else begin
                m_tick = 1'b0;
            end
            @(negedge clk_sys);
            cyc++;
            chk(clk_dfs == m_lvl, {req, " level"}, int'(clk_dfs), int'(m_lvl));
            chk(tick == m_tick, {req, " tick"}, int'(tick), int'(m_tick));
            if (tick) ticks_seen++;
            if (clk_dfs && !prev_lvl) begin
                rises_seen++;
                if (gap_check && last_rise >= 0)
                    chk((cyc - last_rise == 2) || (cyc - last_rise == 3),
                        "R8 rise spacing", cyc - last_rise, 2);
                last_rise = cyc;
            end
            prev_lvl = clk_dfs;
        end
    endtask

    task automatic clear_counts();
        ticks_seen = 0; rises_seen = 0; last_rise = -1;
    endtask

    task automatic t_reset();
        @(negedge clk_sys);
        rst_sys = 1'b1; en = 1'b1; trim = '0;
        step(3, "R1");
        chk(clk_dfs == 1'b0, "R1 clk_dfs low in reset", int'(clk_dfs), 0);
        chk(tick == 1'b0, "R1 tick low in reset", int'(tick), 0);
        rst_sys = 1'b0;
        clear_counts();
        // phases 243, 486, 89: first wrap on third enabled edge
        step(2, "R1 start");
        chk(ticks_seen == 0, "R1 no early tick", ticks_seen, 0);
        step(1, "R1 start");
        chk(tick == 1'b1, "R1 first wrap", int'(tick), 1);
    endtask

    task automatic t_nominal();
        trim = '0; gap_check = 1'b1;
        step(5, "R2");
        clear_counts();
        step(MOD, "R2 R3");
        chk(ticks_seen == NOM, "R4 ticks per window", ticks_seen, NOM);
        chk(rises_seen == NOM, "R4 rises per window", rises_seen, NOM);
        clear_counts();
        step(MOD, "R3");
        chk(ticks_seen == NOM, "R4 second window", ticks_seen, NOM);
        gap_check = 1'b0;
    endtask

    task automatic t_trim(int t, string req);
        trim = TRIM_W'(t);
        step(3, req);
        clear_counts();
        step(MOD, req);
        chk(ticks_seen == exp_inc(t), req, ticks_seen, exp_inc(t));
    endtask

    task automatic t_hold();
        int held;
        trim = '0;
        step(7, "R7 pre");
        held = int'(clk_dfs);
        en = 1'b0;
        clear_counts();
        for (int k = 0; k < 40; k++) begin
            step(1, "R7 hold");
            chk(int'(clk_dfs) == held, "R7 level held", int'(clk_dfs), held);
        end
        chk(ticks_seen == 0, "R7 no tick while off", ticks_seen, 0);
        en = 1'b1;
        step(50, "R7 resume");
    endtask

    task automatic t_midreset();
        trim = TRIM_W'(55);
        step(11, "R1 pre");
        rst_sys = 1'b1;
        step(1, "R1 mid");
        chk(clk_dfs == 1'b0 && tick == 1'b0, "R1 mid-run reset", int'(clk_dfs), 0);
        rst_sys = 1'b0;
        trim = '0;
        step(20, "R1 restart");
    endtask

    initial begin
        t_reset();
        t_nominal();
        t_trim(37,   "R5 positive trim");
        t_trim(-100, "R5 negative trim");
        t_trim(76,   "R6 upper edge exact");
        t_trim(77,   "R6 upper clamp");
        t_trim(300,  "R6 far upper clamp");
        t_trim(-242, "R6 lower edge exact");
        t_trim(-243, "R6 lower clamp");
        t_trim(-400, "R6 far lower clamp");
        t_hold();
        t_midreset();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(20.0 * 200000);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule